// File: doc/BRIEF.md
# Dual-Write-Port Register File with Operand Routing

This block holds the eight 32-bit general registers of a small sequential processor, together with the routing logic that decides which registers an operation reads and writes. The core gives it an operation kind and the two register fields of the current instruction. The block answers at once on two combinational read ports, A and B. At the next rising clock edge it commits up to two results: an arithmetic result through port E and a loaded value through port M. The core keeps the ALU, the memory and the program counter. It feeds the data values back in and asserts a single commit pin for every retiring operation.

A pop writes through both ports in the same cycle. The incremented stack pointer goes in through port E and the loaded word through port M. When both ports name the same register, the M write wins, so popping into the stack pointer loads the stack pointer from memory. A push of the stack pointer reads the old value, because reads always return the contents from before the edge. No data stream crosses this block's edge. All pins are plain control and data pins that are sampled at the clock edge, and there is no valid/ready handshake and no back-pressure.

Top module: `dual_port_regfile`

## Requirements
- R1: While `rst_n` is low, all eight registers are cleared to zero, and they read as zero after reset is released.
- R2: Port A reads `reg_x` for the operation codes 2 (register move), 4 (store), 6 (ALU) and 10 (push). It reads the stack pointer, register 4, for codes 9 (return) and 11 (pop). For every other code it reads nothing.
- R3: Port B reads `reg_y` for codes 6 (ALU), 4 (store) and 5 (load). It reads register 4 for codes 10, 11, 8 (call) and 9. For every other code it reads nothing.
- R4: Port E writes `alu_res` to `reg_y` for codes 2, 3 (immediate move) and 6. It writes to register 4 for codes 10, 11, 8 and 9. For every other code it writes nothing.
- R5: Port M writes `mem_res` to `reg_x` for codes 5 (load) and 11 (pop). For every other code it writes nothing.
- R6: A register ID of 8 or more means "none". Reading it returns zero, and writing to it changes no register.
- R7: Writes take effect only at a rising edge with `commit` high. With `commit` low, every register keeps its value.
- R8: Reads are combinational. A read in the same cycle as a write to the same register returns the value from before the write.
- R9: When ports E and M name the same register in one committed cycle, only the M value is stored. Popping into register 4 leaves the loaded word in register 4.
- R10: A push with `reg_x` = 4 presents the old stack pointer on port A, and the stack pointer then takes the E value.
- R11: In a pop, both read ports present register 4. The E value (the caller's `rd_b`+4) goes to register 4 and the M value goes to `reg_x`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all registers |
| op_kind | input | 4 | Operation code that selects the read and write routing |
| reg_x | input | 4 | First register field of the instruction |
| reg_y | input | 4 | Second register field of the instruction |
| alu_res | input | 32 | Data for write port E |
| mem_res | input | 32 | Data for write port M |
| commit | input | 1 | Allows both writes at the next rising edge |
| rd_a | output | 32 | Read port A data |
| rd_b | output | 32 | Read port B data |

## Verification
The assertions assume that `op_kind`, `reg_x`, `reg_y`, the data inputs and `commit` settle between clock edges and stay steady across the sampling edge. They also assume that a "none" ID is any value from 8 upward. The bench drives every input on the falling edge and reads the outputs shortly after, so both conditions always hold. The sweep covers all 16 operation codes with register fields 0 to 8, so the field values stay within the range that the assertions reason about. The bench models a pop's E value as `rd_b`+4 from outside the block.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE  = 4'd0,
    OP_STOP  = 4'd1,
    OP_MOVRR = 4'd2,
    OP_MOVIR = 4'd3,
    OP_STORE = 4'd4,
    OP_LOAD  = 4'd5,
    OP_ALU   = 4'd6,
    OP_JUMP  = 4'd7,
    OP_CALL  = 4'd8,
    OP_RET   = 4'd9,
    OP_PUSH  = 4'd10,
    OP_POP   = 4'd11
  } op_kind_e;
endpackage

// File: rtl/rf_port_select.sv
module rf_port_select
  import rf_pkg::*;
#(
  parameter int unsigned ID_W  = 4,
  parameter int unsigned SP_ID = 4,
  parameter int unsigned NREGS = 8
) (
  input  logic [OP_W-1:0] op_kind,
  input  logic [ID_W-1:0] reg_x,
  input  logic [ID_W-1:0] reg_y,
  output logic [ID_W-1:0] src_a,
  output logic [ID_W-1:0] src_b,
  output logic [ID_W-1:0] dst_e,
  output logic [ID_W-1:0] dst_m
);
  localparam logic [ID_W-1:0] NONE_ID = ID_W'(NREGS);
  localparam logic [ID_W-1:0] SP      = ID_W'(SP_ID);

  always_comb begin
    src_a = NONE_ID;
    src_b = NONE_ID;
    dst_e = NONE_ID;
    dst_m = NONE_ID;
    case (op_kind_e'(op_kind))
      OP_MOVRR: begin src_a = reg_x; dst_e = reg_y; end
      OP_MOVIR: begin dst_e = reg_y; end
      OP_STORE: begin src_a = reg_x; src_b = reg_y; end
      OP_LOAD:  begin src_b = reg_y; dst_m = reg_x; end
      OP_ALU:   begin src_a = reg_x; src_b = reg_y; dst_e = reg_y; end
      OP_CALL:  begin src_b = SP; dst_e = SP; end
      OP_RET:   begin src_a = SP; src_b = SP; dst_e = SP; end
      OP_PUSH:  begin src_a = reg_x; src_b = SP; dst_e = SP; end
      OP_POP:   begin src_a = SP; src_b = SP; dst_e = SP; dst_m = reg_x; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 8,
  parameter int unsigned ID_W   = 4
) (
  input  logic [NREGS-1:0][DATA_W-1:0] entries,
  input  logic [ID_W-1:0]              sel,
  output logic [DATA_W-1:0]            data
);
  localparam int unsigned IDX_W = $clog2(NREGS);

  always_comb begin
    if (sel < ID_W'(NREGS)) data = entries[sel[IDX_W-1:0]];
    else                    data = '0;
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 8,
  parameter int unsigned ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [ID_W-1:0]   dst_e,
  input  logic [ID_W-1:0]   dst_m,
  input  logic [DATA_W-1:0] wdata_e,
  input  logic [DATA_W-1:0] wdata_m,
  input  logic [ID_W-1:0]   rsel_a,
  input  logic [ID_W-1:0]   rsel_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [NREGS-1:0][DATA_W-1:0] regs_q;

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic hit_e, hit_m;
    assign hit_e = commit && (dst_e == ID_W'(i));
    assign hit_m = commit && (dst_m == ID_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     regs_q[i] <= '0;
      else if (hit_m) regs_q[i] <= wdata_m;
      else if (hit_e) regs_q[i] <= wdata_e;
    end
  end

  rf_read_port #(.DATA_W(DATA_W), .NREGS(NREGS), .ID_W(ID_W)) u_rd_a (
    .entries(regs_q), .sel(rsel_a), .data(rdata_a));
  rf_read_port #(.DATA_W(DATA_W), .NREGS(NREGS), .ID_W(ID_W)) u_rd_b (
    .entries(regs_q), .sel(rsel_b), .data(rdata_b));
endmodule

// File: rtl/dual_port_regfile.sv
module dual_port_regfile
  import rf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 8,
  parameter int unsigned SP_ID  = 4,
  localparam int unsigned ID_W  = $clog2(NREGS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_kind,
  input  logic [ID_W-1:0]   reg_x,
  input  logic [ID_W-1:0]   reg_y,
  input  logic [DATA_W-1:0] alu_res,
  input  logic [DATA_W-1:0] mem_res,
  input  logic              commit,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);
  logic [ID_W-1:0] src_a, src_b, dst_e, dst_m;

  rf_port_select #(.ID_W(ID_W), .SP_ID(SP_ID), .NREGS(NREGS)) u_sel (
    .op_kind(op_kind), .reg_x(reg_x), .reg_y(reg_y),
    .src_a(src_a), .src_b(src_b), .dst_e(dst_e), .dst_m(dst_m));

  rf_storage #(.DATA_W(DATA_W), .NREGS(NREGS), .ID_W(ID_W)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .dst_e(dst_e), .dst_m(dst_m), .wdata_e(alu_res), .wdata_m(mem_res),
    .rsel_a(src_a), .rsel_b(src_b), .rdata_a(rd_a), .rdata_b(rd_b));
endmodule

// File: rtl/rf_checker.sv
module rf_checker
  import rf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 8,
  parameter int unsigned SP_ID  = 4,
  parameter int unsigned ID_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [OP_W-1:0]   op_kind,
  input logic [ID_W-1:0]   reg_x,
  input logic [DATA_W-1:0] alu_res,
  input logic [DATA_W-1:0] mem_res,
  input logic              commit,
  input logic [DATA_W-1:0] rd_a,
  input logic [DATA_W-1:0] rd_b,
  input logic [ID_W-1:0]   src_a,
  input logic [ID_W-1:0]   src_b,
  input logic [ID_W-1:0]   dst_e,
  input logic [ID_W-1:0]   dst_m
);
  localparam logic [ID_W-1:0] NONE_ID = ID_W'(NREGS);
  localparam logic [ID_W-1:0] SP      = ID_W'(SP_ID);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_none_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_a >= NONE_ID) |-> (rd_a == '0)) and ((src_b >= NONE_ID) |-> (rd_b == '0)));

  assert_pop_routing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == OP_POP) |-> (src_a == SP && src_b == SP && dst_e == SP && dst_m == reg_x));

  assert_hold_without_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!commit) && $stable(src_a) && $stable(src_b))
      |-> ($stable(rd_a) && $stable(rd_b)));

  assert_mport_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(commit && dst_m < NONE_ID) && src_a == $past(dst_m))
      |-> (rd_a == $past(mem_res)));

  assert_eport_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(commit && dst_e < NONE_ID && dst_e != dst_m) && src_b == $past(dst_e))
      |-> (rd_b == $past(alu_res)));
endmodule

bind dual_port_regfile rf_checker #(
  .DATA_W(DATA_W), .NREGS(NREGS), .SP_ID(SP_ID), .ID_W(ID_W)
) u_rf_checker (
  .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .reg_x(reg_x),
  .alu_res(alu_res), .mem_res(mem_res), .commit(commit),
  .rd_a(rd_a), .rd_b(rd_b),
  .src_a(src_a), .src_b(src_b), .dst_e(dst_e), .dst_m(dst_m)
);

// File: tb/test_dual_port_regfile.sv
module test_dual_port_regfile;
  localparam time CLK_P = 10ns;
  localparam int  SP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_kind = '0, reg_x = '0, reg_y = '0;
  logic [31:0] alu_res = '0, mem_res = '0;
  logic        commit = 1'b0;
  logic [31:0] rd_a, rd_b;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mdl [8];

  always #(CLK_P/2) clk = ~clk;

  dual_port_regfile i_dual_port_regfile (
    .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .reg_x(reg_x), .reg_y(reg_y),
    .alu_res(alu_res), .mem_res(mem_res), .commit(commit), .rd_a(rd_a), .rd_b(rd_b));

  function automatic int exp_src_a(int op, int x);
    if (op == 2 || op == 4 || op == 6 || op == 10) return x;
    if (op == 9 || op == 11) return SP;
    return 8;
  endfunction
  function automatic int exp_src_b(int op, int y);
    if (op == 4 || op == 5 || op == 6) return y;
    if (op == 8 || op == 9 || op == 10 || op == 11) return SP;
    return 8;
  endfunction
  function automatic int exp_dst_e(int op, int y);
    if (op == 2 || op == 3 || op == 6) return y;
    if (op == 8 || op == 9 || op == 10 || op == 11) return SP;
    return 8;
  endfunction
  function automatic int exp_dst_m(int op, int x);
    if (op == 5 || op == 11) return x;
    return 8;
  endfunction
  function automatic logic [31:0] mread(int id);
    return (id < 8) ? mdl[id] : 32'h0;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  int cur_op, cur_x, cur_y;
  task automatic drive(input int op, input int x, input int y,
                       input logic [31:0] e, input logic [31:0] m, input logic c);
    @(negedge clk);
    op_kind = 4'(op); reg_x = 4'(x); reg_y = 4'(y);
    alu_res = e; mem_res = m; commit = c;
    cur_op = op; cur_x = x; cur_y = y;
    #1;
  endtask

  task automatic retire();
    int de, dm;
    @(posedge clk);
    #1;
    if (commit) begin
      de = exp_dst_e(cur_op, cur_y);
      dm = exp_dst_m(cur_op, cur_x);
      if (de < 8) mdl[de] = alu_res;
      if (dm < 8) mdl[dm] = mem_res;
    end
  endtask

  task automatic step(input int op, input int x, input int y,
                      input logic [31:0] e, input logic [31:0] m, input logic c);
    drive(op, x, y, e, m, c);
    chk(rd_a, mread(exp_src_a(op, x)), $sformatf("R2 op=%0d x=%0d", op, x));
    chk(rd_b, mread(exp_src_b(op, y)), $sformatf("R3 op=%0d y=%0d", op, y));
    retire();
  endtask

  task automatic rdchk(input int id, input logic [31:0] exp, input string tag);
    drive(6, id, id, 32'h0, 32'h0, 1'b0);
    chk(rd_a, exp, $sformatf("%s reg%0d", tag, id));
  endtask

  task automatic dump(input string tag);
    for (int i = 0; i < 8; i++) rdchk(i, mdl[i], tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 32'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: cleared state
    dump("R1");

    // R4 via immediate moves: reg i <- 0x100+i
    for (int i = 0; i < 8; i++) step(3, 8, i, 32'h100 + 32'(i), 32'h0, 1'b1);
    rdchk(5, 32'h105, "R4");

    // R7: commit low leaves state
    step(6, 3, 5, 32'hBAD0_0001, 32'hBAD0_0002, 1'b0);
    step(11, 2, 8, 32'hBAD0_0003, 32'hBAD0_0004, 1'b0);
    rdchk(5, 32'h105, "R7");
    rdchk(2, 32'h102, "R7");

    // R8: same-cycle read sees old value
    drive(6, 2, 2, 32'hDEAD_0002, 32'h0, 1'b1);
    chk(rd_a, 32'h102, "R8 port A");
    chk(rd_b, 32'h102, "R8 port B");
    retire();
    rdchk(2, 32'hDEAD_0002, "R8 after edge");

    // R10: push of stack pointer
    step(3, 8, 4, 32'h80, 32'h0, 1'b1);
    drive(10, 4, 8, 32'h7C, 32'h0, 1'b1);
    chk(rd_a, 32'h80, "R10 old sp on A");
    chk(rd_b, 32'h80, "R10 sp on B");
    retire();
    rdchk(4, 32'h7C, "R10 sp updated");

    // R11: pop into reg0
    drive(11, 0, 8, 32'h0, 32'h55, 1'b1);
    chk(rd_a, 32'h7C, "R11 A reads sp");
    chk(rd_b, 32'h7C, "R11 B reads sp");
    alu_res = rd_b + 32'd4;
    retire();
    rdchk(4, 32'h80, "R11 sp+4");
    rdchk(0, 32'h55, "R11 popped value");

    // R9: pop into stack pointer, M wins
    drive(11, 4, 8, 32'h0, 32'h999, 1'b1);
    alu_res = rd_b + 32'd4;
    retire();
    rdchk(4, 32'h999, "R9 pop sp");

    // R5: load
    step(5, 3, 1, 32'h0, 32'h333, 1'b1);
    rdchk(3, 32'h333, "R5 load");

    // R6: none IDs
    step(3, 8, 8, 32'hBAD, 32'h0, 1'b1);
    step(5, 12, 8, 32'h0, 32'hBAD, 1'b1);
    drive(6, 8, 15, 32'h0, 32'h0, 1'b0);
    chk(rd_a, 32'h0, "R6 read none A");
    chk(rd_b, 32'h0, "R6 read none B");
    dump("R6");

    // Sweep: all codes, fields 0..8 (R2 R3 R4 R5 R9)
    for (int op = 0; op < 16; op++) begin
      for (int x = 0; x <= 8; x++) begin
        for (int y = 0; y <= 8; y++) begin
          step(op, x, y, 32'hE000_0000 + 32'(op * 256 + x * 16 + y),
               32'hA000_0000 + 32'(op * 256 + x * 16 + y), 1'b1);
        end
      end
      dump($sformatf("R4 sweep op=%0d", op));
    end

    summary();
    $finish;
  end
endmodule